// File: doc/BRIEF.md
# Per-Channel Loop Interrupt Controller

This block gathers loop-position events from a bank of voice channels and turns them into one level interrupt line. Every channel presents two offsets on flat input buses: its current playback offset and the offset of its loop end. The block compares the two offsets of each channel. It raises a channel event when playback reaches the loop end, or when it reaches the half-way point of the loop.

Two global enable inputs gate the two kinds of event for the whole bank. A per-channel enable word gates them for each channel. Pending events are held in a status word that software reads and acknowledges by writing ones. Both words sit behind a small register port with a single address bit and a combinational read path.

An event is taken on the rising edge of its gated condition. A position that stays past the threshold therefore does not interrupt again after it has been acknowledged.

Top module: `loop_irq_ctrl`

## Requirements
- R1: After reset, the status word, the enable word and `irq` are all zero.
- R2: Status bit n is set at the clock edge after the gated end condition of channel n rises. The end condition is current offset >= end offset (unsigned), ANDed with `end_ie` and enable bit n.
- R3: Status bit n is set at the clock edge after the gated mid condition of channel n rises. The mid condition is current offset >= (end offset >> 1), with truncation, ANDed with `mid_ie` and enable bit n.
- R4: The enable word sits at register address 1 and reads back what was written. A channel whose enable bit is 0 never sets its status bit.
- R5: `end_ie` and `mid_ie` gate their own event type independently. With both at 0, no status bit is set.
- R6: Status sits at register address 0. A write there clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: Events are taken on the 0-to-1 transition of the gated condition. A condition that stays true does not set the bit again after it is cleared. Enabling a channel whose comparison already holds counts as a transition.
- R8: If a set event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R9: `irq` is high while any status bit is 1. It falls once the last set bit has been cleared.
- R10: Bit n of both words belongs to channel n. The offsets of channel n occupy bits [n*OW +: OW] of `cur_off` and `end_off`, and channels do not affect one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| end_ie | input | 1 | Global enable for loop-end events |
| mid_ie | input | 1 | Global enable for half-loop events |
| cur_off | input | NCH*OW | Current sample offset per channel, packed |
| end_off | input | NCH*OW | Loop end offset per channel, packed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | NCH | Register write data |
| reg_rdata | output | NCH | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
A new event and a software acknowledge of the same status bit can land in the same cycle. The bench provokes this by raising channel 7's end condition on the very edge at which an all-ones write strikes the status word, and it judges the case correct only if bit 7 reads back as 1 afterwards. The neighbouring collision, a condition that keeps holding across an acknowledge, is judged by reading the bit as 0 for two edges after the clear.

// File: rtl/loop_irq_ctrl.sv
module loop_irq_ctrl #(
  parameter int NCH = 32,
  parameter int OW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              end_ie,
  input  logic              mid_ie,
  input  logic [NCH*OW-1:0] cur_off,
  input  logic [NCH*OW-1:0] end_off,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [NCH-1:0]    reg_wdata,
  output logic [NCH-1:0]    reg_rdata,
  output logic              irq
);

  logic [NCH-1:0] status_q, en_q;
  logic [NCH-1:0] cmp_end, cmp_mid;
  logic [NCH-1:0] arm_end, arm_mid;
  logic [NCH-1:0] prev_end_q, prev_mid_q;
  logic [NCH-1:0] set_vec, clr_vec;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [OW-1:0] cur_n, end_n;
    assign cur_n      = cur_off[n*OW +: OW];
    assign end_n      = end_off[n*OW +: OW];
    assign cmp_end[n] = cur_n >= end_n;
    assign cmp_mid[n] = cur_n >= (end_n >> 1);
  end

  assign arm_end = cmp_end & en_q & {NCH{end_ie}};
  assign arm_mid = cmp_mid & en_q & {NCH{mid_ie}};
  assign set_vec = (arm_end & ~prev_end_q) | (arm_mid & ~prev_mid_q);
  assign clr_vec = (reg_wr && !reg_addr) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= '0;
      en_q       <= '0;
      prev_end_q <= '0;
      prev_mid_q <= '0;
    end else begin
      status_q   <= (status_q & ~clr_vec) | set_vec;
      prev_end_q <= arm_end;
      prev_mid_q <= arm_mid;
      if (reg_wr && reg_addr) en_q <= reg_wdata;
    end
  end

  assign reg_rdata = reg_addr ? en_q : status_q;
  assign irq       = |status_q;

endmodule

// File: rtl/loop_irq_ctrl_chk.sv
module loop_irq_ctrl_chk #(
  parameter int NCH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           end_ie,
  input logic           mid_ie,
  input logic           reg_wr,
  input logic           reg_addr,
  input logic [NCH-1:0] reg_wdata,
  input logic [NCH-1:0] status,
  input logic [NCH-1:0] en,
  input logic           irq
);

  logic [NCH-1:0] clr_now;
  assign clr_now = (reg_wr && !reg_addr) ? reg_wdata : '0;

  // R6
  status_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status & ~$past(clr_now)) == '0));

  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(status) & status & ~$past(en)) == '0));

  // R5
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(status) & status) != '0) |-> $past(end_ie || mid_ie));

  // R4
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr) |=> (en == $past(reg_wdata)));

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(end_ie || mid_ie));

endmodule

bind loop_irq_ctrl loop_irq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .end_ie(end_ie), .mid_ie(mid_ie),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .status(status_q), .en(en_q), .irq(irq)
);

// File: tb/loop_irq_ctrl_bench.sv
module loop_irq_ctrl_bench;
  localparam int NCH = 32;
  localparam int OW  = 16;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {cur, end, end_ie, mid_ie, expected bit}
  localparam logic [34:0] VEC [NVEC] = '{
    {16'd100,    16'd100,    1'b1, 1'b0, 1'b1},
    {16'd99,     16'd100,    1'b1, 1'b0, 1'b0},
    {16'd50,     16'd100,    1'b0, 1'b1, 1'b1},
    {16'd49,     16'd100,    1'b0, 1'b1, 1'b0},
    {16'd2,      16'd5,      1'b0, 1'b1, 1'b1},
    {16'd1,      16'd5,      1'b0, 1'b1, 1'b0},
    {16'd0,      16'd0,      1'b1, 1'b0, 1'b1},
    {16'hFFFF,   16'hFFFF,   1'b0, 1'b0, 1'b0},
    {16'd60,     16'd100,    1'b1, 1'b0, 1'b0},
    {16'd60,     16'd100,    1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic end_ie = 1'b0, mid_ie = 1'b0;
  logic [NCH*OW-1:0] cur_off, end_off;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [NCH-1:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_irq_ctrl #(.NCH(NCH), .OW(OW)) u_loop_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .end_ie(end_ie), .mid_ie(mid_ie),
    .cur_off(cur_off), .end_off(end_off), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [NCH-1:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [NCH-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic park();
    cur_off = '0;
    end_off = {NCH*OW{1'b1}};
  endtask

  task automatic set_ch(int ch, logic [OW-1:0] c, logic [OW-1:0] e);
    cur_off[ch*OW +: OW] = c;
    end_off[ch*OW +: OW] = e;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] v;
    park();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    rd(1'b0, v); check("R1 status", v, '0);
    rd(1'b1, v); check("R1 enable", v, '0);
    check("R1 irq", {31'd0, irq}, '0);

    wr(1'b1, '1);
    rd(1'b1, v); check("R4 enable readback", v, '1);

    for (int i = 0; i < NVEC; i++) begin
      park();
      end_ie = VEC[i][2]; mid_ie = VEC[i][1];
      wr(1'b0, '1);
      set_ch(3, VEC[i][34:19], VEC[i][18:3]);
      tick();
      rd(1'b0, v);
      check($sformatf("R2/R3/R5 vector %0d", i), v, {28'd0, VEC[i][0], 3'd0});
      check($sformatf("R9 irq vector %0d", i), {31'd0, irq}, {31'd0, VEC[i][0]});
    end

    // R7: condition of vector 9 still holds on channel 3
    wr(1'b0, 32'h0000_0008);
    rd(1'b0, v); check("R7 cleared while held", v, '0);
    tick();
    rd(1'b0, v); check("R7 no retrigger", v, '0);
    check("R9 irq low", {31'd0, irq}, '0);

    // R10 / R6
    park(); end_ie = 1'b1; mid_ie = 1'b0;
    wr(1'b0, '1);
    set_ch(0, 16'd7, 16'd7); set_ch(31, 16'd9, 16'd8);
    tick();
    rd(1'b0, v); check("R10 channels 0 and 31", v, 32'h8000_0001);
    wr(1'b0, 32'h0000_0001);
    rd(1'b0, v); check("R6 write-1 clears bit 0 only", v, 32'h8000_0000);
    check("R9 irq still high", {31'd0, irq}, 32'd1);
    wr(1'b0, '0);
    rd(1'b0, v); check("R6 write-0 no change", v, 32'h8000_0000);
    wr(1'b0, 32'h8000_0000);
    rd(1'b0, v); check("R6 last bit cleared", v, '0);
    check("R9 irq falls", {31'd0, irq}, '0);

    // R4 per-channel gate, then R7 enable as transition
    park();
    wr(1'b1, ~32'h0000_0020);
    wr(1'b0, '1);
    set_ch(5, 16'd40, 16'd30);
    tick(); tick();
    rd(1'b0, v); check("R4 disabled channel silent", v, '0);
    wr(1'b1, '1);
    tick();
    rd(1'b0, v); check("R7 enable makes edge", v, 32'h0000_0020);

    // R8 set wins over same-cycle clear
    park();
    wr(1'b0, '1);
    tick();
    set_ch(7, 16'd5, 16'd5);
    wr(1'b0, '1);
    rd(1'b0, v); check("R8 set beats clear", v, 32'h0000_0080);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule